// File: doc/BRIEF.md
# Bit-Slice ALU with Condition Flags

This block is a small integer arithmetic logic unit. A chain of identical one-bit slices forms the datapath, and the carry ripples from the least significant slice to the most significant one. Each slice contains a one-bit full adder and a four-way result selector. The slice can complement its A bit, its B bit, or both, before they reach the adder and the logic gates. A two-bit operation code selects what each slice puts on its result bit: the AND of the operands, the OR of the operands, the adder sum, or a less-than indication.

The unit also produces four condition flags: carry, signed overflow, negative and zero. With the right control settings the same hardware gives addition, two's-complement subtraction, signed compare (set-on-less-than) and NOR. The result and the flags are registered, so they appear one clock after the operands and controls are presented. The width is a parameter and defaults to five bits.

Top module: `slice_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge loads `result_o` with 0, loads `carry_o`, `ovf_o` and `neg_o` with 0, and loads `zero_o` with 1.
- R2: All outputs are registered. Inputs sampled at one rising edge appear on the outputs after that edge, and the outputs stay unchanged until the next edge.
- R3: `a_inv_i`=1 makes every slice use the complement of its A bit. `b_neg_i`=1 makes every slice use the complement of its B bit. This applies to all four operations and to the adder.
- R4: `op_i`=2'b00 selects the bitwise AND of the effective operands, and `op_i`=2'b01 selects their bitwise OR.
- R5: `op_i`=2'b10 selects the adder sum. The carry into slice 0 equals `b_neg_i`, so `b_neg_i`=1 gives A minus B in two's complement.
- R6: `op_i`=2'b11 (set-on-less-than) puts 0 on result bits WIDTH-1..1. Bit 0 carries the sign of the adder sum XOR the overflow condition, which is the true signed less-than of the effective A and the effective subtrahend.
- R7: `carry_o` is the carry out of the most significant slice. It is produced for every operation.
- R8: `ovf_o` is the XOR of the carry into the most significant slice and the carry out of it. It is produced for every operation.
- R9: `neg_o` equals bit WIDTH-1 of the registered result.
- R10: `zero_o` is 1 exactly when every bit of the registered result is 0.
- R11: `a_inv_i`=1, `b_neg_i`=1 and `op_i`=2'b00 together give the bitwise NOR of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| a_inv_i | input | 1 | Complement operand A in every slice |
| b_neg_i | input | 1 | Complement operand B and force carry-in to 1 |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 set-on-less-than |
| result_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Result sign bit |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench sweeps every combination of operands and controls. This exposes several kinds of fault. A carry-in not tied to the B complement control would make every subtraction off by one. An overflow flag taken from the wrong carry pair would miss the cases of positive plus positive and negative minus positive. A less-than bit taken from the raw sum sign would give the wrong answer whenever the subtraction overflows, for example the most negative value compared with one. Directed vectors cover the NOR setting, a zero result from equal operands and the reset state. A further check confirms that the outputs hold between edges, which a design with a combinational path to the outputs would break.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SLT = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  always_comb begin
    s_o  = x_i ^ y_i ^ ci_i;
    co_o = (x_i & y_i) | (ci_i & (x_i ^ y_i));
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_inv_i,
  input  logic    b_neg_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    sum_o,
  output logic    carry_o,
  output logic    res_o
);
  logic a_eff, b_eff;

  always_comb begin
    a_eff = a_i ^ a_inv_i;
    b_eff = b_i ^ b_neg_i;
  end

  alu_full_adder u_fa (
    .x_i (a_eff),
    .y_i (b_eff),
    .ci_i(carry_i),
    .s_o (sum_o),
    .co_o(carry_o)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_eff & b_eff;
      OP_OR:   res_o = a_eff | b_eff;
      OP_ADD:  res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_inv_i,
  input  logic             b_neg_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_msb_in_o,
  output logic             carry_out_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] less_v;
  logic             set_bit;

  assign chain[0] = b_neg_i;

  always_comb begin
    set_bit = sums[MSB] ^ (chain[MSB] ^ chain[WIDTH]);
    less_v  = '0;
    less_v[0] = set_bit;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .a_inv_i(a_inv_i),
      .b_neg_i(b_neg_i),
      .carry_i(chain[i]),
      .less_i (less_v[i]),
      .op_i   (op_i),
      .sum_o  (sums[i]),
      .carry_o(chain[i+1]),
      .res_o  (res_o[i])
    );
  end

  assign carry_msb_in_o = chain[MSB];
  assign carry_out_o    = chain[WIDTH];

  always_comb begin
    if (op_i == OP_SLT) begin
      // R6
      slt_upper_chk: assert (res_o[MSB:1] == '0);
    end
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_inv_i,
  input  logic             b_neg_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] res_c;
  logic             c_msb_in, c_out;
  alu_op_e          op_e;

  assign op_e = alu_op_e'(op_i);

  alu_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_i           (a_i),
    .b_i           (b_i),
    .a_inv_i       (a_inv_i),
    .b_neg_i       (b_neg_i),
    .op_i          (op_e),
    .res_o         (res_c),
    .carry_msb_in_o(c_msb_in),
    .carry_out_o   (c_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= res_c;
      carry_o  <= c_out;
      ovf_o    <= c_msb_in ^ c_out;
      neg_o    <= res_c[MSB];
      zero_o   <= ~|res_c;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0 && !carry_o && !ovf_o && !neg_o && zero_o));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  // R9
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    neg_o == result_o[MSB]);

  // R5 R7
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 2'b10 && !$past(a_inv_i) && !$past(b_neg_i))
      |-> ({carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 2'b10 && !$past(a_inv_i) && !$past(b_neg_i))
      |-> (ovf_o == (($past(a_i[MSB]) == $past(b_i[MSB])) &&
                     (result_o[MSB] != $past(a_i[MSB])))));
endmodule

// File: tb/slice_alu_test.sv
module slice_alu_test;
  localparam int W = 5;
  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         ai = 1'b0, bn = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] res;
  logic         c, v, n, z;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  slice_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .a_inv_i(ai), .b_neg_i(bn),
    .op_i(op), .result_o(res), .carry_o(c), .ovf_o(v), .neg_o(n), .zero_o(z)
  );

  // {a, b, ainv, bneg, op, res, c, v, n, z}
  localparam logic [22:0] VEC [NV] = '{
    {5'd3,      5'd4,      1'b0, 1'b0, 2'b10, 5'd7,      1'b0, 1'b0, 1'b0, 1'b0},
    {5'd15,     5'd1,      1'b0, 1'b0, 2'b10, 5'b10000,  1'b0, 1'b1, 1'b1, 1'b0},
    {5'd5,      5'd5,      1'b0, 1'b1, 2'b10, 5'd0,      1'b1, 1'b0, 1'b0, 1'b1},
    {5'd3,      5'd5,      1'b0, 1'b1, 2'b11, 5'd1,      1'b0, 1'b0, 1'b0, 1'b0},
    {5'b01010,  5'b00110,  1'b1, 1'b1, 2'b00, 5'b10001,  1'b1, 1'b1, 1'b1, 1'b0},
    {5'b10000,  5'b00001,  1'b0, 1'b0, 2'b01, 5'b10001,  1'b0, 1'b0, 1'b1, 1'b0},
    {5'b10000,  5'b00001,  1'b0, 1'b1, 2'b11, 5'd1,      1'b1, 1'b1, 1'b0, 1'b0},
    {5'b11111,  5'b00000,  1'b0, 1'b0, 2'b00, 5'd0,      1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h ai=%0b bn=%0b op=%0b)",
               tag, act, exp, a, b, ai, bn, op);
    end
  endtask

  // returns {res, c, v, n, z} from the requirements
  function automatic logic [W+3:0] model(input logic [W-1:0] xa, xb,
                                         input logic xi, xn, input logic [1:0] xo);
    logic [W-1:0] ea, eb, r;
    logic [W:0]   s;
    logic [W-1:0] lo;
    logic         c5, c4, ov;
    ea = xi ? ~xa : xa;
    eb = xn ? ~xb : xb;
    s  = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, xn};
    lo = {1'b0, ea[W-2:0]} + {1'b0, eb[W-2:0]} + {{(W-1){1'b0}}, xn};
    c5 = s[W];
    c4 = lo[W-1];
    ov = c4 ^ c5;
    case (xo)
      2'b00:   r = ea & eb;
      2'b01:   r = ea | eb;
      2'b10:   r = s[W-1:0];
      default: r = {{(W-1){1'b0}}, s[W-1] ^ ov};
    endcase
    return {r, c5, ov, r[W-1], (r == '0)};
  endfunction

  task automatic apply(input logic [W-1:0] xa, xb, input logic xi, xn, input logic [1:0] xo);
    @(negedge clk);
    a = xa; b = xb; ai = xi; bn = xn; op = xo;
    @(posedge clk);
    #1;
  endtask

  function automatic string res_tag(input logic xi, xn, input logic [1:0] xo);
    if (xo == 2'b00 && xi && xn) return "R11";
    case (xo)
      2'b00, 2'b01: return (xi || xn) ? "R3/R4" : "R4";
      2'b10:        return (xi || xn) ? "R3/R5" : "R5";
      default:      return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W+3:0] e;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", {3'b0, res}, 8'd0);
    chk("R1", {4'b0, c, v, n, z}, 8'b0001);
    @(negedge clk);
    rst = 1'b0;

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22:18], VEC[i][17:13], VEC[i][12], VEC[i][11], VEC[i][10:9]);
      chk(res_tag(VEC[i][12], VEC[i][11], VEC[i][10:9]), {3'b0, res}, {3'b0, VEC[i][8:4]});
      chk("R7/R8/R9/R10", {4'b0, c, v, n, z}, {4'b0, VEC[i][3:0]});
    end

    // exhaustive sweep
    for (int k = 0; k < (1 << (2*W + 4)); k++) begin
      logic [2*W+3:0] p;
      p = k[2*W+3:0];
      apply(p[2*W+3:W+4], p[W+3:4], p[3], p[2], p[1:0]);
      e = model(a, b, ai, bn, op);
      chk(res_tag(ai, bn, op), {3'b0, res}, {3'b0, e[W+3:4]});
      chk("R7", {7'b0, c}, {7'b0, e[3]});
      chk("R8", {7'b0, v}, {7'b0, e[2]});
      chk("R9", {7'b0, n}, {7'b0, e[1]});
      chk("R10", {7'b0, z}, {7'b0, e[0]});
    end

    // R2: outputs hold between edges
    apply(5'd9, 5'd6, 1'b0, 1'b0, 2'b10);
    chk("R2", {3'b0, res}, 8'd15);
    @(negedge clk);
    a = 5'd1; b = 5'd1; op = 2'b00;
    #2;
    chk("R2", {3'b0, res}, 8'd15);
    @(posedge clk);
    #1;
    chk("R2", {3'b0, res}, 8'd1);

    // R1: reset during operation
    @(negedge clk);
    a = 5'b11111; b = 5'd1; op = 2'b10; rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", {3'b0, res}, 8'd0);
    chk("R1", {4'b0, c, v, n, z}, 8'b0001);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R5/R7", {2'b0, c, res}, {2'b0, 1'b1, 5'd0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule